// File: doc/BRIEF.md
# Layered Check-Node Posterior Update Datapath

This block carries out the two halves of one layered-decoding step for a single check node, spread over five parallel lanes. There is one lane for each code-bit class: four systematic classes and the parity class. The first half is the vertical pass. For each lane it reads the stored posterior of the variable node taking part in the check. It rebuilds that edge's old extrinsic value from a compressed per-check record, which holds two smallest magnitudes, the position of the smallest one, one sign bit per edge and the product of all signs. Subtracting the rebuilt value from the posterior gives the prior, which is handed to an external check-node unit.

The second half is the horizontal pass. The check-node unit returns a new compressed record. The block rebuilds each edge's new extrinsic value from it, adds that value to the prior it kept aside, and writes the sum back as the new posterior. Extrinsic values are never stored per edge.

One check node touches each lane's memory three times, once per slot. One read and one write per cycle per lane therefore spread a check node over three cycles. A code-rate input switches off the systematic lanes that are unused at the lower rates. A one-shot fill loads every posterior entry with the largest positive value before a frame starts.

Top module: `layered_post_dp`

## Requirements
- R1: An accepted read in slot s gives, on lane k's field `cnu_prior_o[8k+7:8k]`, the stored posterior at that lane's read address minus the old extrinsic value rebuilt for edge position s*5+k. The result is a signed 8-bit value.
- R2: A rebuilt extrinsic value has magnitude `min2` when the edge position equals the record's `idx` field, and `min` otherwise. It is negative when the record's sign-product bit XOR the edge's own bit `signs[position]` is 1, and non-negative otherwise.
- R3: An accepted write in slot s stores, at lane k's write address, the prior kept from the last accepted read of slot s plus the new extrinsic value rebuilt from the `xn_*` record. A later read of that address returns it.
- R4: A one-cycle `init_i` pulse raises `init_busy_o` for exactly 228 cycles and writes +127 into every entry of every lane. Read and write requests made while `init_busy_o` is high are ignored.
- R5: Both the subtraction and the addition clamp to the range -128..+127 instead of wrapping.
- R6: `rate_i` encodes 0 = 1/2, 1 = 2/3, 2 = 3/4 and 3 = 4/5. Lane 4 (parity) is always active, and systematic lane k (0..3) is active when k <= `rate_i`. An inactive lane presents +31 on its prior field and writes nothing back.
- R7: The three slots keep separate priors. A write in slot s uses slot s's prior whatever order the slots are written in.
- R8: `cnu_vld_o` pulses high for one cycle, two clock edges after each accepted read, and is low after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rate_i | input | 2 | Code-rate select (R6 encoding) |
| init_i | input | 1 | Start the posterior fill |
| init_busy_o | output | 1 | Fill in progress |
| rd_vld_i | input | 1 | Vertical-pass read request |
| rd_slot_i | input | 2 | Slot of the read (0..2) |
| rd_addr_i | input | 40 | Per-lane read addresses, 8 bits per lane, lane k at [8k+7:8k] |
| xo_min_i | input | 5 | Old record: smallest magnitude |
| xo_min2_i | input | 5 | Old record: second smallest magnitude |
| xo_idx_i | input | 4 | Old record: position of the smallest |
| xo_sprod_i | input | 1 | Old record: sign product |
| xo_signs_i | input | 15 | Old record: per-edge sign bits |
| wr_vld_i | input | 1 | Horizontal-pass write request |
| wr_slot_i | input | 2 | Slot of the write (0..2) |
| wr_addr_i | input | 40 | Per-lane write addresses, 8 bits per lane |
| xn_min_i | input | 5 | New record: smallest magnitude |
| xn_min2_i | input | 5 | New record: second smallest magnitude |
| xn_idx_i | input | 4 | New record: position of the smallest |
| xn_sprod_i | input | 1 | New record: sign product |
| xn_signs_i | input | 15 | New record: per-edge sign bits |
| cnu_vld_o | output | 1 | Priors valid for the check-node unit |
| cnu_prior_o | output | 40 | Per-lane priors, 8-bit signed, lane k at [8k+7:8k] |

## Verification
A wrong kept prior, such as a slot mix-up or a stale buffer, does not show at once. It shows only when the posterior it produced is read back, one write and one read later, two edges after that read. The bench therefore writes the slots in reverse order and always reads results back. A wrong rebuild rule or sign selection shows on the very next prior, two edges after the read, so each record pattern is chosen to make the minimum index land on a known lane. A missed fill entry or a lane-gating fault shows as a value other than +127 or +31 on the first read that touches it.

// File: rtl/lpd_pkg.sv
package lpd_pkg;

   typedef enum logic [1:0] {
      RATE_HALF  = 2'd0,
      RATE_2_3   = 2'd1,
      RATE_3_4   = 2'd2,
      RATE_4_5   = 2'd3
   } rate_e;

   // Parity lane (the last) always works; systematic lane k works when k <= rate code.
   function automatic logic lane_on(input logic [1:0] rate, input int lane, input int lanes);
      return (lane == lanes - 1) || (lane <= int'(rate));
   endfunction

endpackage

// File: rtl/lpd_ext_expand.sv
module lpd_ext_expand #(
   parameter int EDGES = 15,
   parameter int MW    = 5,
   parameter int EW    = 6,
   parameter int IW    = 4
) (
   input  logic [MW-1:0]        min_i,
   input  logic [MW-1:0]        min2_i,
   input  logic [IW-1:0]        idx_i,
   input  logic                 sprod_i,
   input  logic [EDGES-1:0]     signs_i,
   input  logic [IW-1:0]        pos_i,
   output logic signed [EW-1:0] ext_o
);

   if (EW != MW + 1) begin : g_bad_ew
      $error("lpd_ext_expand: EW must be MW+1");
   end

   logic [MW-1:0] mag;
   logic          neg;

   always_comb begin
      mag   = (pos_i == idx_i) ? min2_i : min_i;
      neg   = sprod_i ^ signs_i[pos_i];
      ext_o = neg ? -$signed({1'b0, mag}) : $signed({1'b0, mag});
   end

endmodule

// File: rtl/lpd_lane.sv
module lpd_lane #(
   parameter int PW       = 8,
   parameter int EW       = 6,
   parameter int DEPTH    = 228,
   parameter int AW       = 8,
   parameter int SLOTS    = 3,
   parameter int SW       = 2,
   parameter int IDLE_MAG = 31
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 en_i,
   input  logic                 init_we_i,
   input  logic [AW-1:0]        init_addr_i,
   input  logic                 rd_vld_i,
   input  logic [AW-1:0]        rd_addr_i,
   input  logic                 s1_vld_i,
   input  logic [SW-1:0]        s1_slot_i,
   input  logic signed [EW-1:0] ext_old_i,
   input  logic                 wr_vld_i,
   input  logic [SW-1:0]        wr_slot_i,
   input  logic [AW-1:0]        wr_addr_i,
   input  logic signed [EW-1:0] ext_new_i,
   output logic signed [PW-1:0] prior_o
);

   localparam int XW    = PW + 2;
   localparam int TOP_I = 2 ** (PW - 1) - 1;
   localparam int BOT_I = -(2 ** (PW - 1));
   localparam logic signed [PW-1:0] TOP_V  = PW'(TOP_I);
   localparam logic signed [PW-1:0] IDLE_V = PW'(IDLE_MAG);

   if (IDLE_MAG > TOP_I) begin : g_bad_idle
      $error("lpd_lane: IDLE_MAG exceeds posterior range");
   end
   if (EW >= PW) begin : g_bad_width
      $error("lpd_lane: extrinsic must be narrower than posterior");
   end

   function automatic logic signed [PW-1:0] clamp(input logic signed [XW-1:0] v);
      if (v > $signed(XW'(TOP_I)))      return PW'(TOP_I);
      else if (v < $signed(XW'(BOT_I))) return PW'(BOT_I);
      else                              return v[PW-1:0];
   endfunction

   logic signed [PW-1:0] mem [DEPTH];
   logic signed [PW-1:0] rdata_q;
   logic signed [PW-1:0] pbuf_q [SLOTS];
   logic signed [PW-1:0] prior_q;
   logic signed [PW-1:0] prior_c;
   logic signed [PW-1:0] post_c;
   logic signed [PW-1:0] kept_c;
   logic signed [XW-1:0] diff_w;
   logic signed [XW-1:0] sum_w;

   always_comb begin
      kept_c = pbuf_q[wr_slot_i];
      diff_w = $signed({{2{rdata_q[PW-1]}}, rdata_q})
             - $signed({{(XW-EW){ext_old_i[EW-1]}}, ext_old_i});
      sum_w  = $signed({{2{kept_c[PW-1]}}, kept_c})
             + $signed({{(XW-EW){ext_new_i[EW-1]}}, ext_new_i});
      prior_c = clamp(diff_w);
      post_c  = clamp(sum_w);
   end

   // Posterior storage: one read port, one write port.
   always_ff @(posedge clk) begin
      if (init_we_i)                 mem[init_addr_i] <= TOP_V;
      else if (wr_vld_i && en_i)     mem[wr_addr_i]   <= post_c;
      if (rd_vld_i)                  rdata_q          <= mem[rd_addr_i];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prior_q <= '0;
         for (int s = 0; s < SLOTS; s++) pbuf_q[s] <= '0;
      end else if (s1_vld_i) begin
         prior_q           <= en_i ? prior_c : IDLE_V;
         pbuf_q[s1_slot_i] <= prior_c;
      end
   end

   assign prior_o = prior_q;

   assert_idle_lane_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (s1_vld_i && !en_i) |=> (prior_o == IDLE_V));

   assert_no_wrap_add_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_vld_i && en_i && !kept_c[PW-1] && !ext_new_i[EW-1]) |-> (post_c >= kept_c));

   assert_no_wrap_sub_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (s1_vld_i && !rdata_q[PW-1] && ext_old_i[EW-1]) |-> (prior_c >= rdata_q));

endmodule

// File: rtl/layered_post_dp.sv
module layered_post_dp #(
   parameter int LANES = 5,
   parameter int PW    = 8,
   parameter int MW    = 5,
   parameter int EW    = MW + 1,
   parameter int DEPTH = 228,
   parameter int SLOTS = 3,
   localparam int AW    = $clog2(DEPTH),
   localparam int SW    = $clog2(SLOTS),
   localparam int EDGES = LANES * SLOTS,
   localparam int IW    = $clog2(EDGES)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [1:0]            rate_i,
   input  logic                  init_i,
   output logic                  init_busy_o,
   input  logic                  rd_vld_i,
   input  logic [SW-1:0]         rd_slot_i,
   input  logic [LANES*AW-1:0]   rd_addr_i,
   input  logic [MW-1:0]         xo_min_i,
   input  logic [MW-1:0]         xo_min2_i,
   input  logic [IW-1:0]         xo_idx_i,
   input  logic                  xo_sprod_i,
   input  logic [EDGES-1:0]      xo_signs_i,
   input  logic                  wr_vld_i,
   input  logic [SW-1:0]         wr_slot_i,
   input  logic [LANES*AW-1:0]   wr_addr_i,
   input  logic [MW-1:0]         xn_min_i,
   input  logic [MW-1:0]         xn_min2_i,
   input  logic [IW-1:0]         xn_idx_i,
   input  logic                  xn_sprod_i,
   input  logic [EDGES-1:0]      xn_signs_i,
   output logic                  cnu_vld_o,
   output logic [LANES*PW-1:0]   cnu_prior_o
);

   localparam int IDLE_MAG = 2 ** MW - 1;

   if (LANES < 2 || LANES > 5) begin : g_bad_lanes
      $error("layered_post_dp: LANES must be 2..5 for a 2-bit rate code");
   end
   if (SLOTS < 2) begin : g_bad_slots
      $error("layered_post_dp: SLOTS must be at least 2");
   end
   if (DEPTH < 2) begin : g_bad_depth
      $error("layered_post_dp: DEPTH must be at least 2");
   end

   // Fill sequencer
   logic [AW-1:0] icnt_q;
   logic          busy_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         icnt_q <= '0;
      end else if (busy_q) begin
         if (icnt_q == AW'(DEPTH - 1)) busy_q <= 1'b0;
         icnt_q <= icnt_q + 1'b1;
      end else if (init_i) begin
         busy_q <= 1'b1;
         icnt_q <= '0;
      end
   end

   assign init_busy_o = busy_q;

   logic rd_acc, wr_acc;
   assign rd_acc = rd_vld_i && !busy_q;
   assign wr_acc = wr_vld_i && !busy_q;

   // Stage 1: read data lands; old record travels alongside.
   logic             s1_vld_q;
   logic [SW-1:0]    s1_slot_q;
   logic [MW-1:0]    o_min_q, o_min2_q;
   logic [IW-1:0]    o_idx_q;
   logic             o_sprod_q;
   logic [EDGES-1:0] o_signs_q;
   logic             cnu_vld_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s1_vld_q  <= 1'b0;
         s1_slot_q <= '0;
         o_min_q   <= '0;
         o_min2_q  <= '0;
         o_idx_q   <= '0;
         o_sprod_q <= 1'b0;
         o_signs_q <= '0;
         cnu_vld_q <= 1'b0;
      end else begin
         s1_vld_q  <= rd_acc;
         cnu_vld_q <= s1_vld_q;
         if (rd_acc) begin
            s1_slot_q <= rd_slot_i;
            o_min_q   <= xo_min_i;
            o_min2_q  <= xo_min2_i;
            o_idx_q   <= xo_idx_i;
            o_sprod_q <= xo_sprod_i;
            o_signs_q <= xo_signs_i;
         end
      end
   end

   assign cnu_vld_o = cnu_vld_q;

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      logic [IW-1:0]        pos_old, pos_new;
      logic signed [EW-1:0] ext_old, ext_new;
      logic signed [PW-1:0] prior;
      logic                 en;

      assign pos_old = IW'(s1_slot_q) * IW'(LANES) + IW'(g);
      assign pos_new = IW'(wr_slot_i) * IW'(LANES) + IW'(g);
      assign en      = lpd_pkg::lane_on(rate_i, g, LANES);

      lpd_ext_expand #(.EDGES(EDGES), .MW(MW), .EW(EW), .IW(IW)) u_old (
         .min_i(o_min_q), .min2_i(o_min2_q), .idx_i(o_idx_q), .sprod_i(o_sprod_q),
         .signs_i(o_signs_q), .pos_i(pos_old), .ext_o(ext_old));

      lpd_ext_expand #(.EDGES(EDGES), .MW(MW), .EW(EW), .IW(IW)) u_new (
         .min_i(xn_min_i), .min2_i(xn_min2_i), .idx_i(xn_idx_i), .sprod_i(xn_sprod_i),
         .signs_i(xn_signs_i), .pos_i(pos_new), .ext_o(ext_new));

      lpd_lane #(.PW(PW), .EW(EW), .DEPTH(DEPTH), .AW(AW), .SLOTS(SLOTS), .SW(SW),
                 .IDLE_MAG(IDLE_MAG)) u_lane (
         .clk(clk), .rst_n(rst_n), .en_i(en),
         .init_we_i(busy_q), .init_addr_i(icnt_q),
         .rd_vld_i(rd_acc), .rd_addr_i(rd_addr_i[g*AW +: AW]),
         .s1_vld_i(s1_vld_q), .s1_slot_i(s1_slot_q), .ext_old_i(ext_old),
         .wr_vld_i(wr_acc), .wr_slot_i(wr_slot_i), .wr_addr_i(wr_addr_i[g*AW +: AW]),
         .ext_new_i(ext_new), .prior_o(prior));

      assign cnu_prior_o[g*PW +: PW] = prior;
   end

   assert_cnu_latency_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_vld_i && !init_busy_o) |-> ##2 cnu_vld_o);

   assert_busy_blocks_R4: assert property (@(posedge clk) disable iff (!rst_n)
      init_busy_o |-> ##2 !cnu_vld_o);

endmodule

// File: tb/layered_post_dp_tb.sv
module layered_post_dp_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int NL = 5;
   localparam int DP = 228;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  rate_i = 2'd3;
   logic        init_i = 1'b0;
   logic        init_busy_o;
   logic        rd_vld_i = 1'b0;
   logic [1:0]  rd_slot_i = '0;
   logic [39:0] rd_addr_i = '0;
   logic [4:0]  xo_min_i = '0, xo_min2_i = '0;
   logic [3:0]  xo_idx_i = '0;
   logic        xo_sprod_i = 1'b0;
   logic [14:0] xo_signs_i = '0;
   logic        wr_vld_i = 1'b0;
   logic [1:0]  wr_slot_i = '0;
   logic [39:0] wr_addr_i = '0;
   logic [4:0]  xn_min_i = '0, xn_min2_i = '0;
   logic [3:0]  xn_idx_i = '0;
   logic        xn_sprod_i = 1'b0;
   logic [14:0] xn_signs_i = '0;
   logic        cnu_vld_o;
   logic [39:0] cnu_prior_o;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;
   int post_m [NL][DP];
   int prior_m [NL][3];

   always #(CLK_PERIOD/2) clk = ~clk;

   layered_post_dp dut_i (
      .clk(clk), .rst_n(rst_n), .rate_i(rate_i), .init_i(init_i), .init_busy_o(init_busy_o),
      .rd_vld_i(rd_vld_i), .rd_slot_i(rd_slot_i), .rd_addr_i(rd_addr_i),
      .xo_min_i(xo_min_i), .xo_min2_i(xo_min2_i), .xo_idx_i(xo_idx_i),
      .xo_sprod_i(xo_sprod_i), .xo_signs_i(xo_signs_i),
      .wr_vld_i(wr_vld_i), .wr_slot_i(wr_slot_i), .wr_addr_i(wr_addr_i),
      .xn_min_i(xn_min_i), .xn_min2_i(xn_min2_i), .xn_idx_i(xn_idx_i),
      .xn_sprod_i(xn_sprod_i), .xn_signs_i(xn_signs_i),
      .cnu_vld_o(cnu_vld_o), .cnu_prior_o(cnu_prior_o));

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   function automatic int sat8(input int v);
      if (v > 127)  return 127;
      if (v < -128) return -128;
      return v;
   endfunction

   // R2 rule: magnitude min2 at the stored index, min elsewhere; sign = product ^ own bit
   function automatic int expand(input int mn, input int mn2, input int ix, input bit sp,
                                 input logic [14:0] sg, input int pos);
      int m;
      bit ng;
      m  = (pos == ix) ? mn2 : mn;
      ng = sp ^ sg[pos];
      return ng ? -m : m;
   endfunction

   function automatic bit lane_on_m(input int rate, input int lane);
      return (lane == 4) || (lane <= rate);
   endfunction

   function automatic int addr_of(input int base, input int lane);
      return (base + 17 * lane) % DP;
   endfunction

   task automatic set_old(input int mn, input int mn2, input int ix, input bit sp, input logic [14:0] sg);
      xo_min_i = 5'(mn); xo_min2_i = 5'(mn2); xo_idx_i = 4'(ix); xo_sprod_i = sp; xo_signs_i = sg;
   endtask

   task automatic set_new(input int mn, input int mn2, input int ix, input bit sp, input logic [14:0] sg);
      xn_min_i = 5'(mn); xn_min2_i = 5'(mn2); xn_idx_i = 4'(ix); xn_sprod_i = sp; xn_signs_i = sg;
   endtask

   // Read one slot and check every lane's prior (R1/R2/R6 per tag) and the valid timing (R8)
   task automatic do_read(input int slot, input int base, input string tag);
      int exp_v [NL];
      for (int k = 0; k < NL; k++) begin
         int p;
         p = sat8(post_m[k][addr_of(base, k)]
                  - expand(int'(xo_min_i), int'(xo_min2_i), int'(xo_idx_i), xo_sprod_i,
                           xo_signs_i, slot * 5 + k));
         prior_m[k][slot] = p;
         exp_v[k] = lane_on_m(int'(rate_i), k) ? p : 31;
      end
      @(negedge clk);
      rd_vld_i = 1'b1;
      rd_slot_i = 2'(slot);
      for (int k = 0; k < NL; k++) rd_addr_i[k*8 +: 8] = 8'(addr_of(base, k));
      @(negedge clk);
      rd_vld_i = 1'b0;
      chk(cnu_vld_o == 1'b0, "R8 valid one cycle after read", int'(cnu_vld_o), 0);
      @(negedge clk);
      chk(cnu_vld_o == 1'b1, "R8 valid two cycles after read", int'(cnu_vld_o), 1);
      for (int k = 0; k < NL; k++) begin
         int a;
         a = int'($signed(cnu_prior_o[k*8 +: 8]));
         chk(a == exp_v[k], $sformatf("%s lane %0d slot %0d", tag, k, slot), a, exp_v[k]);
      end
   endtask

   task automatic do_write(input int slot, input int base);
      for (int k = 0; k < NL; k++)
         if (lane_on_m(int'(rate_i), k))
            post_m[k][addr_of(base, k)] =
               sat8(prior_m[k][slot]
                    + expand(int'(xn_min_i), int'(xn_min2_i), int'(xn_idx_i), xn_sprod_i,
                             xn_signs_i, slot * 5 + k));
      @(negedge clk);
      wr_vld_i = 1'b1;
      wr_slot_i = 2'(slot);
      for (int k = 0; k < NL; k++) wr_addr_i[k*8 +: 8] = 8'(addr_of(base, k));
      @(negedge clk);
      wr_vld_i = 1'b0;
   endtask

   task automatic t_reset;
      chk(cnu_vld_o == 1'b0, "R8 reset valid low", int'(cnu_vld_o), 0);
      chk(init_busy_o == 1'b0, "R4 reset busy low", int'(init_busy_o), 0);
   endtask

   task automatic t_init;
      int n;
      bit seen;
      seen = 1'b0;
      @(negedge clk) init_i = 1'b1;
      @(negedge clk) init_i = 1'b0;
      rd_vld_i = 1'b1;
      n = 0;
      while (init_busy_o === 1'b1 && n < 1000) begin
         n++;
         if (n == 2) rd_vld_i = 1'b0;
         if (n >= 3 && n <= 5 && cnu_vld_o) seen = 1'b1;
         @(negedge clk);
      end
      rd_vld_i = 1'b0;
      chk(n == DP, "R4 busy length", n, DP);
      chk(!seen, "R4 read ignored while busy", int'(seen), 0);
      for (int k = 0; k < NL; k++)
         for (int a = 0; a < DP; a++) post_m[k][a] = 127;
      set_old(0, 0, 0, 1'b0, '0);
      do_read(0, 3, "R4 fill value");
      do_read(1, 227, "R4 fill value last entry");
   endtask

   // Full check node: three reads, writes in reverse slot order, read-back
   task automatic t_layer;
      rate_i = 2'd3;
      set_old(2, 6, 6, 1'b0, 15'h5555);
      do_read(0, 20, "R1 prior");
      do_read(1, 30, "R1 prior");
      do_read(2, 40, "R1 prior");
      set_new(3, 8, 12, 1'b1, 15'h0F0F);
      do_write(2, 40);
      do_write(1, 30);
      do_write(0, 20);
      set_old(0, 0, 0, 1'b0, '0);
      do_read(0, 20, "R3 R7 written back slot order");
      do_read(1, 30, "R3 R7 written back slot order");
      do_read(2, 40, "R3 R7 written back slot order");
   endtask

   task automatic t_expand;
      set_old(5, 9, 7, 1'b0, 15'h00A0);
      do_read(1, 30, "R2 index and own sign");
      set_old(4, 13, 14, 1'b1, 15'h4001);
      do_read(2, 40, "R2 sign product");
      set_old(7, 1, 0, 1'b1, 15'h7FFF);
      do_read(0, 20, "R2 index at edge 0");
   endtask

   task automatic t_rate;
      set_old(0, 0, 0, 1'b0, '0);
      rate_i = 2'd0;
      do_read(0, 150, "R6 rate 1/2 idle lanes");
      set_new(20, 25, 9, 1'b1, '0);
      do_write(0, 150);
      rate_i = 2'd3;
      do_read(0, 150, "R6 idle lanes not written");
      rate_i = 2'd1;
      do_read(1, 150, "R6 rate 2/3 mask");
      rate_i = 2'd2;
      do_read(2, 150, "R6 rate 3/4 mask");
      rate_i = 2'd3;
   endtask

   task automatic t_sat;
      set_new(31, 31, 15, 1'b1, '0);
      for (int i = 0; i < 10; i++) begin
         set_old(0, 0, 0, 1'b0, '0);
         do_read(0, 200, "R5 descending");
         do_write(0, 200);
      end
      do_read(0, 200, "R5 clamp low after add");
      chk(int'($signed(cnu_prior_o[7:0])) == -128, "R5 floor reached",
          int'($signed(cnu_prior_o[7:0])), -128);
      set_old(31, 31, 15, 1'b0, '0);
      do_read(0, 200, "R5 clamp low on subtract");
      set_old(31, 31, 15, 1'b1, '0);
      do_read(0, 3, "R5 clamp high on subtract");
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_init();
      t_layer();
      t_expand();
      t_rate();
      t_sat();
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule